// File: doc/BRIEF.md
# Row/Column Multiplexed Dynamic Memory Controller with Self-Refresh

This block connects a simple requester to a dynamic memory array of 4,194,304 four-bit cells, arranged as 2048 rows by 2048 columns. The requester presents a 22-bit word address, a direction bit and write data under a valid/ready handshake. The controller splits the address and sends it over a single 11-bit pin group in two steps. First it sends the row, with the row strobe active. Then it sends the column, with both strobes active. A write places its data on the array's data-in lines while write enable is active. A read opens the array's output only during the column step and returns the sensed nibble to the requester as a one-cycle response pulse.

Dynamic cells lose their charge, so the controller also refreshes the array on its own. A programmable interval counter raises a refresh request. The controller then opens one row with only the row strobe, which makes the array sense that row and write it back. The next row in sequence comes up at each refresh. Refresh requests are served between accesses. They never split an access that has already started.

Top module: `dram_mux_ctrl`

## Requirements
- R1: While reset is held, the row strobe, column strobe, chip enable, write enable and output enable (all active low) are high, `rsp_valid` is low and `req_ready` is high.
- R2: For an accepted request, the cycle after acceptance drives address bits [21:11] on `mem_addr` with the row strobe low and the column strobe high. The next cycle drives bits [10:0] with both strobes low. `mem_ce_n` is low exactly while the row strobe is low.
- R3: An access holds the row strobe low for exactly two consecutive cycles. The column strobe goes low only in the second of them.
- R4: A write drives `mem_we_n` low and `req_wdata` on `mem_din` only during its column cycle. Write enable and output enable are never low together.
- R5: A read drives `mem_oe_n` low only during its column cycle. `rsp_valid` pulses high for exactly the one cycle after that column cycle, carrying the nibble last written to that 22-bit address (zero if the address was never written).
- R6: `req_ready` is high only when the controller is idle and no refresh is pending. A request is taken on a cycle where `req_valid` and `req_ready` are both high.
- R7: A nonzero `refresh_interval` of N raises a refresh request every N cycles. A value of 0 stops all refresh.
- R8: A refresh holds the row strobe low for RF_CYC cycles (3 by default), with the column strobe, write enable and output enable high. The refresh row stays steady on `mem_addr` throughout.
- R9: Refresh rows start at 0 after reset, step up by one per refresh, and wrap from 2047 back to 0.
- R10: A pending refresh is served before a waiting request, so refreshes keep occurring under continuous traffic. They never fall inside an access's row-strobe window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | Word address, row in [21:11], column in [10:0] |
| req_wdata | input | 4 | Write data |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 4 | Read data |
| refresh_interval | input | 16 | Cycles between refresh requests, 0 disables |
| mem_addr | output | 11 | Shared row/column address pins |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_din | output | 4 | Data to the array |
| mem_dout | input | 4 | Sensed data from the array |

## Verification
A latched row or column that goes stale shows up in the strobe window of the same access. The wrong address appears on the pins within two cycles of acceptance. Read-back then returns another cell's nibble within four cycles. A refresh row counter that skips or fails to wrap shows on the pins at the very next refresh. If the row sequence has slipped, the check at 2047 wrapping to 0 fails after 2048 refreshes. A pending-refresh flag stuck high shows at once as `req_ready` held low, and the watchdog catches the hang. A flag stuck low shows as no refresh within one interval.

// File: rtl/dram_mux_ctrl.sv
module dram_mux_ctrl #(
  parameter int ROW_W  = 11,
  parameter int COL_W  = 11,
  parameter int DATA_W = 4,
  parameter int IVL_W  = 16,
  parameter int RF_CYC = 3,
  parameter int PIN_W  = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic [DATA_W-1:0]      req_wdata,
  output logic                   rsp_valid,
  output logic [DATA_W-1:0]      rsp_rdata,
  input  logic [IVL_W-1:0]       refresh_interval,
  output logic [PIN_W-1:0]       mem_addr,
  output logic                   mem_ras_n,
  output logic                   mem_cas_n,
  output logic                   mem_ce_n,
  output logic                   mem_oe_n,
  output logic                   mem_we_n,
  output logic [DATA_W-1:0]      mem_din,
  input  logic [DATA_W-1:0]      mem_dout
);
  localparam int RCW = $clog2(RF_CYC + 1);

  typedef enum logic [2:0] {S_IDLE, S_ROW, S_COL, S_PRE, S_RF, S_RPRE} st_t;
  st_t st;

  logic [ROW_W-1:0]  row_q, rf_row;
  logic [COL_W-1:0]  col_q;
  logic              wr_q;
  logic [DATA_W-1:0] wd_q;
  logic [IVL_W-1:0]  iv_cnt;
  logic              rf_pend;
  logic [RCW-1:0]    rf_cnt;

  wire iv_on  = refresh_interval != '0;
  wire iv_hit = iv_on && (iv_cnt >= refresh_interval - 1'b1);
  wire rf_go  = (st == S_IDLE) && rf_pend;

  assign req_ready = (st == S_IDLE) && !rf_pend;
  assign mem_ras_n = !(st == S_ROW || st == S_COL || st == S_RF);
  assign mem_cas_n = !(st == S_COL);
  assign mem_ce_n  = mem_ras_n;
  assign mem_we_n  = !(st == S_COL && wr_q);
  assign mem_oe_n  = !(st == S_COL && !wr_q);
  assign mem_din   = wd_q;
  assign mem_addr  = (st == S_RF)  ? PIN_W'(rf_row) :
                     (st == S_COL) ? PIN_W'(col_q)  : PIN_W'(row_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iv_cnt  <= '0;
      rf_pend <= 1'b0;
    end else begin
      if (!iv_on || iv_hit) iv_cnt <= '0;
      else                  iv_cnt <= iv_cnt + 1'b1;
      if (iv_hit)     rf_pend <= 1'b1;
      else if (rf_go) rf_pend <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      row_q     <= '0;
      col_q     <= '0;
      wr_q      <= 1'b0;
      wd_q      <= '0;
      rf_row    <= '0;
      rf_cnt    <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        S_IDLE: begin
          if (rf_pend) begin
            st     <= S_RF;
            rf_cnt <= '0;
          end else if (req_valid) begin
            st    <= S_ROW;
            row_q <= req_addr[ROW_W+COL_W-1:COL_W];
            col_q <= req_addr[COL_W-1:0];
            wr_q  <= req_write;
            wd_q  <= req_wdata;
          end
        end
        S_ROW: st <= S_COL;
        S_COL: begin
          st <= S_PRE;
          if (!wr_q) begin
            rsp_valid <= 1'b1;
            rsp_rdata <= mem_dout;
          end
        end
        S_PRE: st <= S_IDLE;
        S_RF: begin
          if (rf_cnt == RCW'(RF_CYC - 1)) begin
            st     <= S_RPRE;
            rf_row <= rf_row + 1'b1;
          end else begin
            rf_cnt <= rf_cnt + 1'b1;
          end
        end
        S_RPRE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r3_cas_after_row: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cas_n |-> $past(!mem_ras_n && mem_cas_n));
  a_r4_we_oe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_we_n && !mem_oe_n));
  a_r5_rsp_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  a_r5_rsp_after_read_col: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(!mem_cas_n && !mem_oe_n));
  a_r6_ready_not_pending: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !rf_pend);
  a_r7_pend_needs_interval: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rf_pend) |-> $past(refresh_interval) != '0);
  a_r8_rf_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RF && $past(st == S_RF)) |-> $stable(mem_addr));
  a_r9_row_step: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_row != $past(rf_row)) |-> (rf_row == $past(rf_row) + 1'b1));
endmodule

// File: tb/dram_mux_ctrl_tb_top.sv
module dram_mux_ctrl_tb_top;
  localparam int RF_CYC = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [21:0] req_addr = '0;
  logic [3:0]  req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [3:0]  rsp_rdata;
  logic [15:0] refresh_interval = '0;
  logic [10:0] mem_addr;
  logic        mem_ras_n, mem_cas_n, mem_ce_n, mem_oe_n, mem_we_n;
  logic [3:0]  mem_din;
  logic [3:0]  mem_dout = '0;

  always #4 clk = ~clk;

  dram_mux_ctrl #(.RF_CYC(RF_CYC)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .refresh_interval(refresh_interval),
    .mem_addr(mem_addr), .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_din(mem_din), .mem_dout(mem_dout)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
  endtask

  // behavioural array
  logic [3:0]  arr [int];
  logic [10:0] row_lat = '0;
  logic        prev_ras = 1'b1;
  always @(negedge clk) begin
    if (!mem_ras_n && prev_ras) row_lat = mem_addr;
    if (!mem_cas_n && !mem_we_n) arr[{row_lat, mem_addr}] = mem_din;
    if (!mem_cas_n && !mem_oe_n)
      mem_dout <= arr.exists({row_lat, mem_addr}) ? arr[{row_lat, mem_addr}] : 4'h0;
    else
      mem_dout <= 4'h0;
    prev_ras = mem_ras_n;
  end

  // scoreboard state
  typedef struct { bit wr; logic [21:0] a; logic [3:0] d; } acc_t;
  acc_t        acc_q [$];
  logic [3:0]  exp_q [$];
  logic [3:0]  ref_m [int];
  int          cyc = 0;
  always @(posedge clk) cyc++;

  task automatic drive(input bit wr, input logic [21:0] a, input logic [3:0] d);
    acc_t it;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    it.wr = wr; it.a = a; it.d = d;
    acc_q.push_back(it);
    if (wr) ref_m[a] = d;
    else exp_q.push_back(ref_m.exists(a) ? ref_m[a] : 4'h0);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // pin and response monitor
  int         run_len = 0, cas_pos = 0, fall_t = 0;
  logic [10:0] run_row = '0, run_col = '0;
  bit         run_on = 0, cas_seen = 0, addr_steady = 1;
  logic [10:0] exp_rf_row = '0;
  int         rf_count = 0, rf_last_t = 0, rf_prev_t = 0;
  bit         wrap_seen = 0, prev_rd_col = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (rsp_valid || prev_rd_col) begin
        chk(rsp_valid == prev_rd_col, "R5", "rsp_valid timing", rsp_valid, prev_rd_col);
        if (rsp_valid) begin
          if (exp_q.size() == 0) chk(0, "R5", "unexpected response", rsp_rdata, 0);
          else begin
            logic [3:0] e;
            e = exp_q.pop_front();
            chk(rsp_rdata == e, "R5", "read data", rsp_rdata, e);
          end
        end
      end
      prev_rd_col = !mem_cas_n && !mem_oe_n;
      if (mem_ce_n != mem_ras_n) chk(0, "R2", "chip enable tracks row strobe", mem_ce_n, mem_ras_n);
      if (mem_cas_n && (!mem_we_n || !mem_oe_n))
        chk(0, "R4", "enable outside column cycle", {mem_we_n, mem_oe_n}, 3);
      if (!mem_ras_n) begin
        if (!run_on) begin
          run_on = 1; run_len = 0; cas_seen = 0; addr_steady = 1;
          run_row = mem_addr; fall_t = cyc;
        end else if (mem_cas_n && mem_addr != run_row) addr_steady = 0;
        run_len++;
        if (!mem_cas_n) begin
          cas_seen = 1; cas_pos = run_len; run_col = mem_addr;
          if (acc_q.size() > 0) begin
            chk(mem_we_n == !acc_q[0].wr, "R4", "write enable in column", mem_we_n, !acc_q[0].wr);
            chk(mem_oe_n == acc_q[0].wr, "R5", "output enable in column", mem_oe_n, acc_q[0].wr);
            if (acc_q[0].wr) chk(mem_din == acc_q[0].d, "R4", "write data", mem_din, acc_q[0].d);
          end
        end
      end else if (run_on) begin
        run_on = 0;
        if (cas_seen) begin
          chk(run_len == 2, "R10", "access strobe window length", run_len, 2);
          chk(cas_pos == 2, "R3", "column strobe position", cas_pos, 2);
          if (acc_q.size() == 0) chk(0, "R2", "access without request", run_row, 0);
          else begin
            acc_t it;
            it = acc_q.pop_front();
            chk(run_row == it.a[21:11], "R2", "row phase address", run_row, it.a[21:11]);
            chk(run_col == it.a[10:0], "R2", "column phase address", run_col, it.a[10:0]);
          end
        end else begin
          chk(run_len == RF_CYC, "R8", "refresh strobe length", run_len, RF_CYC);
          chk(addr_steady, "R8", "refresh row steady", addr_steady, 1);
          chk(run_row == exp_rf_row, "R9", "refresh row", run_row, exp_rf_row);
          if (exp_rf_row == 11'd0 && rf_count > 0) wrap_seen = 1;
          exp_rf_row = exp_rf_row + 1'b1;
          rf_prev_t = rf_last_t; rf_last_t = fall_t;
          rf_count++;
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R6 watchdog actual=hung expected=finished");
      report();
      $finish;
    end
  end

  initial begin
    logic [21:0] pool [8];
    int c0;
    repeat (2) @(negedge clk);
    // R1: reset values
    chk({mem_ras_n, mem_cas_n, mem_ce_n, mem_we_n, mem_oe_n} == 5'h1f, "R1", "strobes idle in reset",
        {mem_ras_n, mem_cas_n, mem_ce_n, mem_we_n, mem_oe_n}, 5'h1f);
    chk(rsp_valid == 0, "R1", "no response in reset", rsp_valid, 0);
    chk(req_ready == 1, "R1", "ready in reset", req_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1, "R6", "ready after reset", req_ready, 1);

    // corner addresses with refresh off
    drive(1, 22'h000000, 4'h5);
    drive(1, 22'h3FFFFF, 4'hA);
    drive(1, 22'h155555, 4'h3);
    drive(1, 22'h2AAAAA, 4'hC);
    drive(1, 22'h2AA555, 4'h9);   // same column as 155555, other row
    drive(0, 22'h000000, 4'h0);
    drive(0, 22'h3FFFFF, 4'h0);
    drive(0, 22'h155555, 4'h0);
    drive(0, 22'h2AA555, 4'h0);
    drive(0, 22'h2AAAAA, 4'h0);
    drive(0, 22'h123456, 4'h0);   // never written
    drive(1, 22'h000000, 4'hF);   // overwrite
    drive(0, 22'h000000, 4'h0);
    repeat (300) @(negedge clk);
    chk(rf_count == 0, "R7", "no refresh when interval is zero", rf_count, 0);

    // interval spacing while idle
    refresh_interval = 16'd40;
    c0 = rf_count;
    wait (rf_count == c0 + 3);
    chk(rf_last_t - rf_prev_t == 40, "R7", "refresh spacing", rf_last_t - rf_prev_t, 40);

    // mixed traffic under frequent refresh
    refresh_interval = 16'd8;
    for (int i = 0; i < 8; i++) pool[i] = 22'((i * 22'h0A5A53) + 22'h001357);
    c0 = rf_count;
    for (int i = 0; i < 150; i++) begin
      int k;
      k = int'($urandom % 8);
      drive(($urandom % 2) == 1, pool[k], 4'($urandom));
    end
    chk(rf_count > c0, "R10", "refresh served under traffic", rf_count - c0, 1);

    // row counter wrap
    refresh_interval = 16'd6;
    wait (rf_count >= 2060);
    chk(wrap_seen, "R9", "row counter wrapped 2047 to 0", wrap_seen, 1);

    refresh_interval = 16'd0;
    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R5", "all reads answered", exp_q.size(), 0);
    chk(acc_q.size() == 0, "R2", "all accesses seen on pins", acc_q.size(), 0);
    done = 1;
    report();
    $finish;
  end
endmodule